// File: doc/BRIEF.md
# Pulse Frequency Window Detector

This block decides whether a pulse train arriving on an unsynchronised pin runs faster than an upper limit or slower than a lower limit. It works in periods. A counter runs on the reference clock, and each rising edge of the input samples the counter and restarts it. The sampled value is the spacing between edges in reference clocks. Each limit is a period preset, computed as reference clock frequency divided by the input frequency at that limit.

The slow side uses a retriggerable timer. Every edge whose measured spacing is short enough reloads the timer. If the timer reaches zero with no reload, the input is reported as too slow. The fast side comes straight from comparing each measured spacing against the upper-limit preset. Each fault flag also feeds a sticky copy, which holds until it is cleared.

Top module: `freq_window_det`

## Requirements
- R1: While reset is high and on the first cycle after it, all four fault outputs are 0. Reset also loads the timer with its full value.
- R2: The pulse input passes through two synchroniser flops and a rising-edge detector. A pulse that is high for one reference clock counts as one event. A pulse that stays high for several clocks also counts as exactly one event.
- R3: The value sampled at a detected edge equals the number of reference clocks since the previous detected edge. A steady train with period P reference clocks gives P at every edge.
- R4: The running count saturates at 2^CNT_W-1 and does not wrap. After a gap longer than that, the edge that ends the gap measures 2^CNT_W-1.
- R5: A detected edge whose measured spacing is less than or equal to `lo_limit` reloads the timer with TMO_LOAD. An edge with a larger spacing does not reload it.
- R6: `too_low` is 1 when the timer is at zero. If the rising edge that causes the last reload is applied on the input just after clock edge t, `too_low` is still 0 after clock edge t+TMO_LOAD+2 and is 1 after clock edge t+TMO_LOAD+3. With TMO_LOAD above the input period, a steady train with period P gives `too_low` = (P > `lo_limit`).
- R7: `too_high` is set at a detected edge whose measured spacing is below `hi_limit`. It is cleared at a detected edge with spacing of at least `hi_limit`. It is also cleared one cycle after the running count reaches `hi_limit` with no edge. A steady train gives `too_high` = (P < `hi_limit`).
- R8: `too_low_held` and `too_high_held` go to 1 on the clock after the matching live flag is 1. They stay at 1 after the live flag returns to 0.
- R9: While `latch_clr` is 1, both held outputs are 0 on the next clock, even if a live flag is 1 at the same time. Clear takes priority over set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| pulse_in | input | 1 | Asynchronous pulse train under test |
| lo_limit | input | CNT_W | Longest allowed period in reference clocks (lower frequency limit) |
| hi_limit | input | CNT_W | Shortest allowed period in reference clocks (upper frequency limit) |
| latch_clr | input | 1 | Clears both held fault outputs |
| too_low | output | 1 | Input is slower than the lower limit |
| too_high | output | 1 | Input is faster than the upper limit |
| too_low_held | output | 1 | Sticky copy of too_low |
| too_high_held | output | 1 | Sticky copy of too_high |

## Verification
The bench sweeps the input period across both limits, one clock at a time, so that the off-by-one boundaries show up directly. A design that compares with the wrong strictness gets the flag wrong at exactly one period. It drives a long input stall with a narrow counter. A wrapping counter would alias the stall into a short, valid period and withdraw `too_low`. It drives a wide-duty input, which a level-sensitive reset would misread as a fast input that raises `too_high`. It times the expiry of the timer to the exact clock, and it checks that clear wins over set when both occur in the same cycle.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    // Wide carrier used by the helper functions; every counter width fits.
    typedef logic [31:0] wide_t;

    // Live or held fault pair; index constants follow the packed layout.
    typedef struct packed {
        logic low;
        logic high;
    } fault_t;

    localparam int FLT_HIGH = 0;
    localparam int FLT_LOW  = 1;
    localparam int FLT_NUM  = 2;

    // Increment that sticks at the ceiling instead of wrapping.
    function automatic wide_t sat_next(wide_t cur, wide_t ceiling);
        return (cur >= ceiling) ? ceiling : cur + 32'd1;
    endfunction

    // Bits needed to hold a timer preload value.
    function automatic int tmo_width(int load);
        return (load < 2) ? 1 : $clog2(load + 1);
    endfunction

endpackage

// File: rtl/fwd_rise_sync.sv
module fwd_rise_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    // Synchroniser stages plus one extra flop for the edge compare.
    localparam int SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh <= '0;
        end else begin
            sh <= {sh[SH_W-2:0], async_in};
        end
    end

    assign rise = sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];

endmodule

// File: rtl/fwd_period_ctr.sv
module fwd_period_ctr
    import fwd_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rise,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_inc;

    // The wide result never exceeds CNT_MAX, so the truncation is safe.
    always_comb begin
        cnt_inc = CNT_W'(sat_next(32'(cnt), 32'(CNT_MAX)));
    end

    // The clock on which an edge is seen counts as the first clock
    // of the next period.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (rise) begin
            cnt <= CNT_ONE;
        end else begin
            cnt <= cnt_inc;
        end
    end

endmodule

// File: rtl/fwd_window_cmp.sv
module fwd_window_cmp #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rise,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] lo_limit,
    input  logic [CNT_W-1:0] hi_limit,
    output logic             lo_ok,
    output logic             too_high
);
    logic short_vs_hi;
    logic hi_reached;

    always_comb begin
        short_vs_hi = (cnt <  hi_limit);
        hi_reached  = (cnt >= hi_limit);
        // The lower-limit comparator fires once per qualifying edge.
        lo_ok       = rise && (cnt <= lo_limit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            too_high <= 1'b0;
        end else if (rise) begin
            too_high <= short_vs_hi;
        end else if (hi_reached) begin
            too_high <= 1'b0;
        end
    end

endmodule

// File: rtl/fwd_retrig_timer.sv
module fwd_retrig_timer
    import fwd_pkg::*;
#(
    parameter int LOAD = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic retrig,
    output logic expired
);
    localparam int           TW     = tmo_width(LOAD);
    localparam logic [TW-1:0] LOAD_V = TW'(LOAD);

    logic [TW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= LOAD_V;
        end else if (retrig) begin
            remain <= LOAD_V;
        end else if (remain != '0) begin
            remain <= remain - TW'(1);
        end
    end

    assign expired = (remain == '0);

endmodule

// File: rtl/fwd_fault_latch.sv
module fwd_fault_latch #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic [N-1:0] live,
    output logic [N-1:0] held
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                held[i] <= 1'b0;
            end else if (live[i]) begin
                held[i] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/freq_window_det.sv
module freq_window_det
    import fwd_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int TMO_LOAD    = 40000,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pulse_in,
    input  logic [CNT_W-1:0] lo_limit,
    input  logic [CNT_W-1:0] hi_limit,
    input  logic             latch_clr,
    output logic             too_low,
    output logic             too_high,
    output logic             too_low_held,
    output logic             too_high_held
);
    logic             rise_det;
    logic [CNT_W-1:0] period_cnt;
    logic             lo_ok;
    logic             hi_fast;
    logic             slow_exp;
    fault_t           live_f;
    fault_t           held_f;

    fwd_rise_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pulse_in),
        .rise     (rise_det)
    );

    fwd_period_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk  (clk),
        .rst  (rst),
        .rise (rise_det),
        .cnt  (period_cnt)
    );

    fwd_window_cmp #(.CNT_W(CNT_W)) u_cmp (
        .clk      (clk),
        .rst      (rst),
        .rise     (rise_det),
        .cnt      (period_cnt),
        .lo_limit (lo_limit),
        .hi_limit (hi_limit),
        .lo_ok    (lo_ok),
        .too_high (hi_fast)
    );

    fwd_retrig_timer #(.LOAD(TMO_LOAD)) u_tmo (
        .clk     (clk),
        .rst     (rst),
        .retrig  (lo_ok),
        .expired (slow_exp)
    );

    always_comb begin
        live_f.low  = slow_exp;
        live_f.high = hi_fast;
    end

    fwd_fault_latch #(.N(FLT_NUM)) u_latch (
        .clk  (clk),
        .rst  (rst),
        .clr  (latch_clr),
        .live (live_f),
        .held (held_f)
    );

    assign too_low       = live_f.low;
    assign too_high      = live_f.high;
    assign too_low_held  = held_f.low;
    assign too_high_held = held_f.high;

endmodule

// File: rtl/fwd_checker.sv
module fwd_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             rise_det,
    input logic [CNT_W-1:0] period_cnt,
    input logic [CNT_W-1:0] lo_limit,
    input logic [CNT_W-1:0] hi_limit,
    input logic             latch_clr,
    input logic             too_low,
    input logic             too_high,
    input logic             too_low_held,
    input logic             too_high_held
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    p_sat_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (period_cnt == CNT_MAX && !rise_det) |=> (period_cnt == CNT_MAX));

    p_reload_r5: assert property (@(posedge clk) disable iff (rst)
        (rise_det && period_cnt <= lo_limit) |=> !too_low);

    p_high_set_r7: assert property (@(posedge clk) disable iff (rst)
        (rise_det && period_cnt < hi_limit) |=> too_high);

    p_high_drop_r7: assert property (@(posedge clk) disable iff (rst)
        (!rise_det && period_cnt >= hi_limit) |=> !too_high);

    p_held_set_r8: assert property (@(posedge clk) disable iff (rst)
        (too_high && !latch_clr) |=> too_high_held);

    p_held_keep_r8: assert property (@(posedge clk) disable iff (rst)
        (too_low_held && !latch_clr) |=> too_low_held);

    p_clear_wins_r9: assert property (@(posedge clk) disable iff (rst)
        latch_clr |=> (!too_low_held && !too_high_held));

endmodule

bind freq_window_det fwd_checker #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .rise_det      (rise_det),
    .period_cnt    (period_cnt),
    .lo_limit      (lo_limit),
    .hi_limit      (hi_limit),
    .latch_clr     (latch_clr),
    .too_low       (too_low),
    .too_high      (too_high),
    .too_low_held  (too_low_held),
    .too_high_held (too_high_held)
);

// File: tb/freq_window_det_tb.sv
`timescale 1ns/1ps
module freq_window_det_tb;
    localparam int CW = 6;
    localparam int TL = 40;

    logic          clk = 1'b0;
    logic          rst;
    logic          pulse_in;
    logic [CW-1:0] lo_limit;
    logic [CW-1:0] hi_limit;
    logic          latch_clr;
    logic          too_low, too_high, too_low_held, too_high_held;

    int nchk = 0;
    int nerr = 0;

    always #2 clk = ~clk;

    freq_window_det #(.CNT_W(CW), .TMO_LOAD(TL)) u_dut (
        .clk           (clk),
        .rst           (rst),
        .pulse_in      (pulse_in),
        .lo_limit      (lo_limit),
        .hi_limit      (hi_limit),
        .latch_clr     (latch_clr),
        .too_low       (too_low),
        .too_high      (too_high),
        .too_low_held  (too_low_held),
        .too_high_held (too_high_held)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic act, input logic exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // One input period of p clocks, high for hw clocks at its start.
    task automatic pulse_cycle(input int p, input int hw);
        pulse_in = 1'b1;
        tick(hw);
        pulse_in = 1'b0;
        tick(p - hw);
    endtask

    task automatic run(input int p, input int hw, input int n);
        for (int k = 0; k < n; k++) pulse_cycle(p, hw);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        rst = 1'b1; pulse_in = 1'b0; latch_clr = 1'b0;
        lo_limit = CW'(20); hi_limit = CW'(8);
        tick(4);
        check("R1 too_low in reset", too_low, 1'b0);
        rst = 1'b0;
        tick(1);
        check("R1 too_low", too_low, 1'b0);
        check("R1 too_high", too_high, 1'b0);
        check("R1 too_low_held", too_low_held, 1'b0);
        check("R1 too_high_held", too_high_held, 1'b0);

        // Period sweep across both limits with single-clock pulses (R2, R3).
        for (int p = 2; p <= 30; p++) begin
            run(p, 1, 8);
            check($sformatf("R3 R6 R5 too_low period=%0d", p), too_low, (p > 20));
            check($sformatf("R3 R7 too_high period=%0d", p), too_high, (p < 8));
        end

        // Wide duty: one event per high phase (R2).
        run(10, 6, 8);
        check("R2 wide pulse too_high", too_high, 1'b0);
        check("R2 wide pulse too_low", too_low, 1'b0);

        // Timeout timing and counter saturation (R6, R4).
        lo_limit = CW'(40);
        run(10, 1, 6);
        check("R5 reload keeps too_low low", too_low, 1'b0);
        tick(TL - 8);
        check("R6 timer not yet expired", too_low, 1'b0);
        tick(1);
        check("R6 timer expired", too_low, 1'b1);
        tick(100 - TL - 3);
        pulse_cycle(5, 1);
        check("R4 saturated gap no reload", too_low, 1'b1);
        lo_limit = CW'(20);

        // Held flags (R8, R9).
        run(10, 1, 8);
        latch_clr = 1'b1;
        tick(1);
        check("R9 clear low held", too_low_held, 1'b0);
        check("R9 clear high held", too_high_held, 1'b0);
        latch_clr = 1'b0;
        tick(1);
        check("R8 no spurious high held", too_high_held, 1'b0);
        run(5, 1, 8);
        check("R7 fast input", too_high, 1'b1);
        tick(7);
        check("R7 drops on running count", too_high, 1'b0);
        run(10, 1, 8);
        check("R7 normal input", too_high, 1'b0);
        check("R8 high held stays", too_high_held, 1'b1);
        check("R8 low held untouched", too_low_held, 1'b0);
        latch_clr = 1'b1;
        run(5, 1, 2);
        check("R7 live during clear", too_high, 1'b1);
        check("R9 clear beats set", too_high_held, 1'b0);
        latch_clr = 1'b0;
        tick(1);
        check("R8 set after clear released", too_high_held, 1'b1);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule